// File: doc/BRIEF.md
# Up-Down Modulo-m Counter

This block is a bidirectional counter whose modulus `m` is a parameter and may be any integer from 2 up to `2^WIDTH`. It does not have to be a power of two. The count cycles through every value from 0 to m-1 and wraps at both ends. An asynchronous clear takes effect at once. All other operations happen on the rising clock edge and are gated by a clock enable. With the enable high, the block can do a synchronous clear, a parallel load of the data input, an increment modulo m or a decrement modulo m.

A terminal-count flag marks the last step before a wrap. When counting up, that step is at m-1. When counting down, it is at 0. The flag is combinational and is raised only while the counter is enabled and actually counting.

Internally, the control inputs are decoded into one named operation per cycle:

- `OP_HOLD`: the enable is low.
- `OP_ZERO`: synchronous clear.
- `OP_LOAD`: parallel load.
- `OP_UP`: increment.
- `OP_DOWN`: decrement.

The next-value stage applies that operation. A single register stores the count. There are no other states or transitions. When m equals `2^WIDTH`, a generate branch uses the plain binary wrap of the adder.

Top module: `updn_mod_counter`

## Requirements
- R1: Repeated counting in one direction from any value in range visits each of the m values 0..m-1 exactly once per m enabled counting cycles.
- R2: While `arst` is 1, `count` is 0 without waiting for a clock edge, whatever the other inputs do.
- R3: With `arst` 0 and `en` 0, `count` keeps its value across clock edges, and `sclr`, `load_sel`, `up_sel` and `din` have no effect.
- R4: With `en` 1 and `sclr` 1, the next rising edge sets `count` to 0. This takes priority over a load or a count.
- R5: With `en` 1, `sclr` 0 and `load_sel` 1 (1 selects load, 0 selects count), a rising edge copies `din` into `count`. `term` is 0 during a load cycle.
- R6: With `en` 1, `sclr` 0 and `load_sel` 0, a rising edge sets `count` to (count+1) mod m when `up_sel` is 1, and to (count-1) mod m when `up_sel` is 0.
- R7: `term` is 1 exactly when `en`=1, `sclr`=0, `load_sel`=0 and either `up_sel`=1 with `count`=m-1, or `up_sel`=0 with `count`=0.
- R8: Incrementing from m-1 gives 0, and decrementing from 0 gives m-1.
- R9: If a load leaves `count` at m or above, the next increment gives 0 and the next decrement gives m-1. `term` stays 0 for such a value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous clear, active high |
| en | input | 1 | Clock enable; 0 holds the count |
| sclr | input | 1 | Synchronous clear, active high |
| load_sel | input | 1 | 1 = parallel load, 0 = count |
| up_sel | input | 1 | 1 = count up, 0 = count down |
| din | input | WIDTH | Parallel load data |
| count | output | WIDTH | Current count value |
| term | output | 1 | Terminal count flag (combinational) |

## Verification
A corrupted stored count appears on `count` in the same cycle. It also changes `term` at once, because the flag is decoded from the stored value with no register in between. A wrong next-value decision, such as a missed wrap or the wrong operation priority, appears on `count` one edge after the offending inputs. The bench therefore checks `term` before each edge and `count` just after it. It also runs complete sweeps in both directions, which expose a wrong modulus within m cycles. Out-of-range loads check that the wrap compare does not rely on exact equality.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_ZERO = 3'd1,
        OP_LOAD = 3'd2,
        OP_UP   = 3'd3,
        OP_DOWN = 3'd4
    } cnt_op_e;

endpackage

// File: rtl/updn_op_decode.sv
module updn_op_decode
    import updn_cnt_pkg::*;
(
    input  logic    en,
    input  logic    sclr,
    input  logic    load_sel,
    input  logic    up_sel,
    output cnt_op_e op
);

    // Priority: enable, then synchronous clear, then load, then count.
    always_comb begin
        if (!en)
            op = OP_HOLD;
        else if (sclr)
            op = OP_ZERO;
        else if (load_sel)
            op = OP_LOAD;
        else if (up_sel)
            op = OP_UP;
        else
            op = OP_DOWN;
    end

endmodule

// File: rtl/updn_next_value.sv
module updn_next_value
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 10
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(MODULUS - 1);
    localparam bit               FULL    = (MODULUS == (2 ** WIDTH));

    logic [WIDTH-1:0] inc_val;
    logic [WIDTH-1:0] dec_val;

    generate
        if (FULL) begin : g_full_range
            // Every code is legal: natural binary wrap.
            assign inc_val = cur + 1'b1;
            assign dec_val = cur - 1'b1;
        end else begin : g_partial_range
            // Values at or above m-1 wrap to 0 on increment.
            assign inc_val = (cur >= TOP_VAL) ? '0 : cur + 1'b1;
            // 0 and out-of-range values go to m-1 on decrement.
            assign dec_val = ((cur == '0) || (cur > TOP_VAL)) ? TOP_VAL : cur - 1'b1;
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_HOLD: nxt = cur;
            OP_ZERO: nxt = '0;
            OP_LOAD: nxt = din;
            OP_UP:   nxt = inc_val;
            OP_DOWN: nxt = dec_val;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/updn_mod_counter.sv
module updn_mod_counter
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 10
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             en,
    input  logic             sclr,
    input  logic             load_sel,
    input  logic             up_sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             term
);

    localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(MODULUS - 1);

    cnt_op_e          op;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    updn_op_decode u_decode (
        .en       (en),
        .sclr     (sclr),
        .load_sel (load_sel),
        .up_sel   (up_sel),
        .op       (op)
    );

    updn_next_value #(
        .WIDTH   (WIDTH),
        .MODULUS (MODULUS)
    ) u_next (
        .op  (op),
        .cur (cnt_q),
        .din (din),
        .nxt (cnt_d)
    );

    // State register with asynchronous clear.
    always_ff @(posedge clk or posedge arst) begin
        if (arst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // Output process: count and terminal-count flag.
    always_comb begin
        count = cnt_q;
        unique case (op)
            OP_UP:   term = (cnt_q == TOP_VAL);
            OP_DOWN: term = (cnt_q == '0);
            default: term = 1'b0;
        endcase
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (arst)
        !en |=> $stable(count));

    assert_sclr_R4: assert property (@(posedge clk) disable iff (arst)
        (en && sclr) |=> (count == '0));

    assert_load_R5: assert property (@(posedge clk) disable iff (arst)
        (en && !sclr && load_sel) |=> (count == $past(din)));

    assert_term_gate_R7: assert property (@(posedge clk) disable iff (arst)
        term |-> (en && !sclr && !load_sel));

    assert_wrap_up_R8: assert property (@(posedge clk) disable iff (arst)
        (en && !sclr && !load_sel && up_sel && count == TOP_VAL) |=> (count == '0));

    assert_wrap_down_R8: assert property (@(posedge clk) disable iff (arst)
        (en && !sclr && !load_sel && !up_sel && count == '0) |=> (count == TOP_VAL));

    assert_range_R9: assert property (@(posedge clk) disable iff (arst)
        (en && !sclr && !load_sel) |=> (count <= TOP_VAL));

endmodule

// File: tb/test_updn_mod_counter.sv
module test_updn_mod_counter;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int M = 10;

    logic         clk = 1'b0;
    logic         arst;
    logic         en;
    logic         sclr;
    logic         load_sel;
    logic         up_sel;
    logic [W-1:0] din;
    logic [W-1:0] count;
    logic         term;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    updn_mod_counter #(.WIDTH(W), .MODULUS(M)) i_updn_mod_counter (
        .clk      (clk),
        .arst     (arst),
        .en       (en),
        .sclr     (sclr),
        .load_sel (load_sel),
        .up_sel   (up_sel),
        .din      (din),
        .count    (count),
        .term     (term)
    );

    // Fields: en, sclr, load_sel, up_sel, din[3:0], exp_term (before edge), exp_count[3:0] (after edge)
    localparam int NV = 19;
    localparam logic [12:0] VEC [NV] = '{
        13'b1_0_1_0_0111_0_0111, // R5 load 7
        13'b1_0_0_1_0000_0_1000, // R6 up
        13'b1_0_0_1_0000_0_1001, // R6 up to m-1
        13'b1_0_0_1_0000_1_0000, // R8 wrap up, term
        13'b1_0_0_0_0000_1_1001, // R8 wrap down, term
        13'b1_0_0_0_0000_0_1000, // R6 down
        13'b0_0_0_1_0000_0_1000, // R3 hold
        13'b0_1_1_0_0011_0_1000, // R3 hold ignores sclr/load
        13'b1_0_1_1_1001_0_1001, // R5 load 9, term gated
        13'b1_1_0_1_0000_0_0000, // R4 sclr, term gated
        13'b1_1_1_0_0101_0_0000, // R4 sclr beats load
        13'b0_1_0_0_0000_0_0000, // R3 en low beats sclr
        13'b1_0_1_1_1111_0_1111, // R9 load 15
        13'b1_0_0_1_0000_0_0000, // R9 out-of-range up
        13'b1_0_1_0_1100_0_1100, // R9 load 12
        13'b1_0_0_0_0000_0_1001, // R9 out-of-range down
        13'b0_0_1_0_0011_0_1001, // R3 hold ignores din
        13'b1_0_0_1_0000_1_0000, // R7 term up
        13'b1_0_0_0_0000_1_1001  // R7 term down
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic e, input logic s, input logic l, input logic u, input logic [W-1:0] d);
        en = e; sclr = s; load_sel = l; up_sel = u; din = d;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        arst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, '0);
        repeat (2) @(negedge clk);
        #1;
        chk("R2 reset count", int'(count), 0);
        chk("R7 reset term", int'(term), 0);
        @(negedge clk);
        arst = 1'b0;

        // Table walk: inputs at negedge, term before edge, count after edge.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
            #1;
            chk($sformatf("R7 vec%0d term", i), int'(term), int'(VEC[i][4]));
            @(posedge clk);
            #1;
            chk($sformatf("R6 vec%0d count", i), int'(count), int'(VEC[i][3:0]));
            @(negedge clk);
        end

        // R1/R8: full upward sweep from 0 counts m steps and one term pulse.
        drive(1'b1, 1'b1, 1'b0, 1'b1, '0);
        @(negedge clk);
        begin
            int pulses = 0;
            int exp = 0;
            drive(1'b1, 1'b0, 1'b0, 1'b1, '0);
            for (int k = 0; k < M; k++) begin
                #1;
                if (term) pulses++;
                @(posedge clk);
                #1;
                exp = (exp + 1) % M;
                chk("R1 up sweep", int'(count), exp);
                @(negedge clk);
            end
            chk("R1 up sweep term pulses", pulses, 1);
        end

        // R1/R8: full downward sweep.
        begin
            int pulses = 0;
            int exp = 0;
            drive(1'b1, 1'b0, 1'b0, 1'b0, '0);
            for (int k = 0; k < M; k++) begin
                #1;
                if (term) pulses++;
                @(posedge clk);
                #1;
                exp = (exp + M - 1) % M;
                chk("R1 down sweep", int'(count), exp);
                @(negedge clk);
            end
            chk("R1 down sweep term pulses", pulses, 1);
        end

        // R2: asynchronous clear between edges, then held across an edge with load active.
        drive(1'b1, 1'b0, 1'b1, 1'b0, 4'd6);
        @(posedge clk);
        #1;
        chk("R5 load 6", int'(count), 6);
        #(CLK_PERIOD / 4);
        arst = 1'b1;
        #1;
        chk("R2 async clear immediate", int'(count), 0);
        @(posedge clk);
        #1;
        chk("R2 clear wins over load", int'(count), 0);
        @(negedge clk);
        arst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0, '0);
        #1;
        chk("R7 term low when disabled at 0", int'(term), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule